// File: doc/BRIEF.md
# Packed SIMD Rounding Variable Shifter

This block shifts every lane of a packed data vector by its own signed amount. The amount for each lane is the low byte of the matching lane of a second vector. A positive amount shifts the lane left. A negative amount shifts it right by the magnitude and rounds to nearest, so half-way values round upward.

Three control inputs are sampled together with the operands. A two-bit size code sets the lane width. A mode bit sets whether data lanes are signed or unsigned. A width bit sets whether the operation covers 128 or 64 bits. The shift amounts are always read as signed, whatever the mode bit says.

The result is registered. It appears one clock after an accepted input and is marked by `out_valid`. The block is meant to sit in a vector execution pipeline, after operand read and before writeback.

Top module: `simd_rnd_shift`

## Requirements
- R1: `lane_size` sets the lane width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Lane i covers bits [i*W +: W] of both operands. Its shift amount is bits [i*W +: 8] of `shamt_b`, read as two's complement (-128..127).
- R2: A lane whose shift amount is zero passes its data through unchanged.
- R3: A shift amount s with 0 < s < W shifts the lane left by s bits. Vacated bits are filled with zeros, and bits pushed past the top of the lane are lost, with no saturation.
- R4: A shift amount s with s >= W gives a zero lane.
- R5: A shift amount -n with n < W gives (x + 2^(n-1)) >> n. The sum is formed one bit wider than the lane, so the carry is kept. The shift is arithmetic when `uns_mode` is 0 and logical when `uns_mode` is 1.
- R6: A shift amount of exactly -W gives the lane's top bit (the rounding carry) in unsigned mode and zero in signed mode. Any amount -n with n > W gives zero.
- R7: Lanes are independent. No carry or shifted bit crosses a lane boundary.
- R8: With `quad` at 0, only bits [63:0] take part, and `result[127:64]` is zero.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `result` holds that input's outcome.
- R10: While `in_valid` is low, `result` keeps its value. Synchronous reset clears `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are accepted this cycle |
| quad | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| lane_size | input | 2 | Lane width code |
| uns_mode | input | 1 | 1: unsigned data lanes, 0: signed data lanes |
| data_a | input | 128 | Packed data vector |
| shamt_b | input | 128 | Packed vector holding a signed shift amount in each lane's low byte |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Packed shifted result |

## Verification
Every result comes out of a single register stage. The bench drives operands on a falling edge with `in_valid` high, and at the next falling edge it compares `out_valid` and `result` against its own reference model. It then drops `in_valid` and checks, one falling edge later, that `out_valid` is low and the result is unchanged. The directed cases cover the rounding carry, an exact lane-width right shift in both modes, over-range amounts and the half-width mode. Seeded random vectors over all sizes and modes follow the same one-cycle timing.

// File: rtl/simd_rs_pkg.sv
`timescale 1ns/1ps
package simd_rs_pkg;
    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int CNT_W     = 8;
    localparam int NUM_SIZES = 4;
    localparam int MIN_LANE  = 8;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } lane_sz_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } pipe_t;
endpackage

// File: rtl/simd_rs_lane.sv
`timescale 1ns/1ps
module simd_rs_lane #(
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic [W-1:0]     x,
    input  logic [CNT_W-1:0] cnt,
    input  logic             uns,
    output logic [W-1:0]     y
);
    logic [W:0]       ext;
    logic [CNT_W-1:0] mag;

    always_comb begin
        y   = '0;
        ext = '0;
        mag = CNT_W'(~cnt) + CNT_W'(1);
        if (!cnt[CNT_W-1]) begin
            if (cnt < CNT_W'(W)) begin
                y = x << cnt;
            end
        end else if (mag <= CNT_W'(W)) begin
            ext = {(~uns & x[W-1]), x} + ((W+1)'(1) << (mag - CNT_W'(1)));
            if (uns) begin
                y = W'(ext >> mag);
            end else begin
                y = W'($signed(ext) >>> mag);
            end
        end
    end
endmodule

// File: rtl/simd_rs_group.sv
`timescale 1ns/1ps
module simd_rs_group #(
    parameter int VW    = 128,
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  logic          uns,
    output logic [VW-1:0] y
);
    localparam int LANES = VW / W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_rs_lane #(.W(W), .CNT_W(CNT_W)) u_lane (
            .x   (a[i*W +: W]),
            .cnt (b[i*W +: CNT_W]),
            .uns (uns),
            .y   (y[i*W +: W])
        );
    end
endmodule

// File: rtl/simd_rnd_shift.sv
`timescale 1ns/1ps
module simd_rnd_shift
    import simd_rs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             quad,
    input  logic [1:0]       lane_size,
    input  logic             uns_mode,
    input  logic [VEC_W-1:0] data_a,
    input  logic [VEC_W-1:0] shamt_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    logic [VEC_W-1:0] grp_res [NUM_SIZES];
    logic [VEC_W-1:0] sel_res;
    pipe_t            st_d, st_q;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        simd_rs_group #(
            .VW    (VEC_W),
            .W     (MIN_LANE << k),
            .CNT_W (CNT_W)
        ) u_grp (
            .a   (data_a),
            .b   (shamt_b),
            .uns (uns_mode),
            .y   (grp_res[k])
        );
    end

    always_comb begin
        sel_res = grp_res[lane_size];
        if (!quad) begin
            sel_res[VEC_W-1:HALF_W] = '0;
        end
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = sel_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/simd_rs_checker.sv
`timescale 1ns/1ps
module simd_rs_checker
    import simd_rs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             quad,
    input logic [VEC_W-1:0] data_a,
    input logic [VEC_W-1:0] shamt_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    // R9: an accepted input is answered on the next cycle
    a_r9_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: no input, no valid
    a_r9_idle_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10: the result is held while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8: half-width mode clears the upper half
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !quad) |=> (result[VEC_W-1:HALF_W] == '0));

    // R2: all-zero amounts pass the data through, for every lane size
    a_r2_identity: assert property (@(posedge clk) disable iff (rst)
        (in_valid && quad && (shamt_b == '0)) |=> (result == $past(data_a)));
endmodule

bind simd_rnd_shift simd_rs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .quad      (quad),
    .data_a    (data_a),
    .shamt_b   (shamt_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/simd_rnd_shift_test.sv
`timescale 1ns/1ps
module simd_rnd_shift_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         quad = 1'b0;
    logic [1:0]   lane_size = 2'b00;
    logic         uns_mode = 1'b0;
    logic [127:0] data_a = '0;
    logic [127:0] shamt_b = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_rnd_shift uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .quad(quad),
        .lane_size(lane_size), .uns_mode(uns_mode), .data_a(data_a),
        .shamt_b(shamt_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] ref_lane(logic [63:0] x, int w, int c, bit uns);
        logic [63:0]        m;
        logic signed [65:0] v;
        int                 n;
        m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        x = x & m;
        if (c >= 0) begin
            if (c >= w) return 64'd0;
            return (x << c) & m;
        end
        n = -c;
        if (n > w) return 64'd0;
        v = $signed({2'b00, x});
        if (!uns && x[w-1]) v = v - (66'sd1 <<< w);
        v = v + (66'sd1 <<< (n - 1));
        v = v >>> n;
        return v[63:0] & m;
    endfunction

    function automatic logic [127:0] ref_vec(logic [127:0] a, logic [127:0] b,
                                             logic [1:0] sz, bit uns, bit q);
        logic [127:0] r;
        int w, lanes;
        r = '0;
        w = 8 << sz;
        lanes = (q ? 128 : 64) / w;
        for (int i = 0; i < lanes; i++) begin
            logic [63:0] x;
            logic [7:0]  cb;
            x  = 64'(a >> (i * w));
            cb = 8'(b >> (i * w));
            r  = r | (128'(ref_lane(x, w, int'($signed(cb)), uns)) << (i * w));
        end
        return r;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, result due at the next falling edge
    task automatic run(string tag, logic [127:0] a, logic [127:0] b,
                       logic [1:0] sz, bit uns, bit q, logic [127:0] exp);
        data_a = a; shamt_b = b; lane_size = sz; uns_mode = uns; quad = q;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 128'(out_valid), 128'd1);
        check(tag, result, exp);
    endtask

    task automatic run_ref(string tag, logic [127:0] a, logic [127:0] b,
                           logic [1:0] sz, bit uns, bit q);
        run(tag, a, b, sz, uns, q, ref_vec(a, b, sz, uns, q));
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] hold;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset valid", 128'(out_valid), 128'd0);
        check("R10 reset result", result, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2: zero amount is identity
        run("R2 identity 16b", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, '0, 2'b01, 1'b0, 1'b1,
            128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        // R3: left shift loses the top bit
        run("R3 left 8b", 128'h81, 128'h01, 2'b00, 1'b0, 1'b1, 128'h02);
        // R4: left by lane width gives zero
        run("R4 left 16b by 16", 128'hFFFF, 128'h10, 2'b01, 1'b1, 1'b1, 128'h0);
        // R5: unsigned 7 >> 1 rounds to 4
        run("R5 u8 round", 128'h07, 128'hFF, 2'b00, 1'b1, 1'b1, 128'h04);
        // R5: signed -7 >> 1 rounds to -3
        run("R5 s8 round", 128'hF9, 128'hFF, 2'b00, 1'b0, 1'b1, 128'hFD);
        // R5: unsigned 255 >> 1 keeps the carry: 128
        run("R5 u8 carry", 128'hFF, 128'hFF, 2'b00, 1'b1, 1'b1, 128'h80);
        // R6: exact lane width right shift
        run("R6 u8 by -8 top set", 128'h80, 128'hF8, 2'b00, 1'b1, 1'b1, 128'h01);
        run("R6 u8 by -8 top clear", 128'h7F, 128'hF8, 2'b00, 1'b1, 1'b1, 128'h00);
        run("R6 s8 by -8", 128'h80, 128'hF8, 2'b00, 1'b0, 1'b1, 128'h00);
        run("R6 u8 by -9", 128'hFF, 128'hF7, 2'b00, 1'b1, 1'b1, 128'h00);
        run("R6 u64 by -64", 128'h8000_0000_0000_0000, 128'hC0, 2'b11, 1'b1, 1'b1, 128'h1);
        // R1: amount taken from the low byte only; upper lane bits ignored
        run("R1 low byte 32b", 128'h0000_0001, 128'h7F00_0004, 2'b10, 1'b1, 1'b1, 128'h10);
        // R7: carry out of lane 0 does not reach lane 1
        run("R7 no cross 8b", 128'h00FF, 128'h00FF, 2'b00, 1'b1, 1'b1, 128'h0080);
        run("R7 left no cross 8b", 128'h0080, 128'h0001, 2'b00, 1'b1, 1'b1, 128'h0000);
        // R8: half-width mode clears the upper half
        run("R8 half width", {64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, '0, 2'b11, 1'b0, 1'b0,
            128'h1);

        // R9 / R10: idle cycle
        hold = result;
        @(negedge clk);
        check("R9 idle valid", 128'(out_valid), 128'd0);
        check("R10 hold", result, hold);

        // random mix over every size and mode (R1 R3 R5 R7 R8)
        for (int t = 0; t < 400; t++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if (t % 3 == 0) begin
                for (int j = 0; j < 16; j++) begin
                    b[j*8 +: 8] = 8'($signed($urandom_range(0, 140)) - 70);
                end
            end
            run_ref("R1 R3 R5 R7 R8 random", a, b, 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule